// File: doc/BRIEF.md
# Cycle-by-Cycle PWM Latch with Two-Channel Output Steering

This block is the digital core of a fixed-frequency pulse-width modulator. A cycle-start pulse from the oscillator sets a latch, which turns the power switch on. A comparator trip (sensed current or a ramp crossing the error level) clears the latch, and it stays clear until the next cycle start. Under overload the trip simply comes earlier in each cycle, so the pulse shortens cycle by cycle for as long as the overload lasts. A dead-time flag from the oscillator forces the latch clear, so the oscillator's dead time sets the maximum duty.

The latch drives two output channels, A and B. Each channel has a high-side and a low-side driver enable, with a break-before-make gap between them. A mode input picks the steering. In full mode both channels follow the latch together. In alternating mode the cycles are handed to A and B in turn, so each channel is capped at half duty and the two run in antiphase. The enable input and a soft-zero request both force zero duty. When enable is low, every driver enable is also off.

Top module: `pwm_steer_core`

## Requirements
- R1: A `cyc_start` sampled high at clock edge s, with `en` high and `blank`/`soft_zero` low, sets the latch. The low-side enable of each channel that owns the cycle drops after edge s+1. Its high-side enable rises after edge s+GAP_CYC+1, provided the low side was lit before.
- R2: A `trip` sampled high at edge t while the latch is set, and without a coincident `cyc_start`, clears the latch. The high side drops after edge t+1, the low side rises after edge t+GAP_CYC+1, and the pulse stays off until the next cycle start.
- R3: In a channel the high-side and low-side enables are never both 1. Between one side going off and the other coming on, both are 0 for at least GAP_CYC clocks.
- R4: With `half_mode` = 0, channels A and B carry identical waveforms.
- R5: With `half_mode` = 1, the cycles are assigned alternately. The first cycle start after `en` rises goes to channel A, the next to B, and so on. The channel that does not own a cycle keeps its low side on, and the two high sides are never on together.
- R6: `half_mode` is sampled only at a cycle start. A change in the middle of a cycle does not alter the steering until the next start.
- R7: A `trip` while the latch is already clear (for example a second trip in the same cycle) has no effect: the low side stays on and the next cycle starts normally.
- R8: When `cyc_start` and `trip` are sampled at the same edge, the start wins. The latch sets and the pulse runs until a later trip or the dead time.
- R9: `blank` high forces the latch clear, with priority over `cyc_start`. Without any trip, the high side therefore drops one edge after the dead-time edge, and the gap before the next pulse is GAP_CYC clocks.
- R10: While `soft_zero` is high, the latch never sets, the duty is zero and the low sides stay on.
- R11: After reset, and on the edge after any edge where `en` is sampled low, all four driver enables are 0. When `en` returns, the low sides come on again after GAP_CYC edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable; low forces every driver enable off |
| cyc_start | input | 1 | One-clock pulse at the start of each oscillator cycle |
| blank | input | 1 | Oscillator dead-time flag; forces the latch clear |
| trip | input | 1 | Comparator trip; clears the latch |
| half_mode | input | 1 | 0 = both channels in phase, 1 = alternating half-duty steering |
| soft_zero | input | 1 | Forces zero duty while high |
| a_hi | output | 1 | Channel A high-side enable |
| a_lo | output | 1 | Channel A low-side enable |
| b_hi | output | 1 | Channel B high-side enable |
| b_lo | output | 1 | Channel B low-side enable |

## Verification
A comparator trip and a cycle start can be sampled at the same edge, and so can a dead-time flag and a trip. The bench provokes the first by raising `trip` in the very clock that carries `cyc_start`, right after a cycle that ran to full duty. It then expects the high sides to come on after the short dead-time gap and to stay on until the following dead time, which is the start-wins rule. A second trip later in an already-tripped cycle, and a mode flip in the middle of an alternating cycle, are judged by the low-side enables and by the owner channel staying as they were.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  // number of steered output channels
  localparam int NUM_CH = 2;

  // owner of an oscillator cycle in alternating mode
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

endpackage

// File: rtl/pwm_set_latch.sv
module pwm_set_latch (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic soft_zero,
  input  logic blank,
  input  logic cyc_start,
  input  logic trip,
  output logic on_q
);

  // priority: disable / soft zero / dead time, then start, then trip
  always_ff @(posedge clk) begin
    if (rst || !en || soft_zero || blank) begin
      on_q <= 1'b0;
    end else if (cyc_start) begin
      on_q <= 1'b1;
    end else if (trip) begin
      on_q <= 1'b0;
    end
  end

  // R2
  trip_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (trip && !cyc_start) |=> !on_q);

  // R8
  start_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && en && !soft_zero && !blank) |=> on_q);

  // R10
  soft_zero_chk: assert property (@(posedge clk) disable iff (rst)
    soft_zero |=> !on_q);

  // R7
  idle_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (!on_q && !cyc_start) |=> !on_q);

endmodule

// File: rtl/pwm_phase_steer.sv
module pwm_phase_steer
  import pwm_steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cyc_start,
  input  logic              half_mode,
  input  logic              latch_on,
  output logic [NUM_CH-1:0] want,
  output logic              mode_q
);

  chan_e owner_q;

  // owner parks on B while disabled so the first start hands the cycle to A
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      owner_q <= CH_B;
      mode_q  <= 1'b0;
    end else if (cyc_start) begin
      owner_q <= (owner_q == CH_A) ? CH_B : CH_A;
      mode_q  <= half_mode;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_want
    localparam chan_e ME = (c == 0) ? CH_A : CH_B;
    assign want[c] = latch_on && (!mode_q || (owner_q == ME));
  end

  // R5
  owner_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && en) |=> (owner_q != $past(owner_q)));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !cyc_start) |=> $stable(mode_q));

endmodule

// File: rtl/pwm_bbm_stage.sv
module pwm_bbm_stage #(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic want,
  output logic hi_q,
  output logic lo_q
);

  localparam int            CW    = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] GAP_V = CW'(GAP_CYC);
  localparam logic [CW-1:0] ONE_V = CW'(1);

  logic [CW-1:0] off_cnt;

  // off_cnt counts clocks with both sides dark; it restarts only when a side is lit
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      off_cnt <= '0;
    end else if (hi_q && !want) begin
      hi_q    <= 1'b0;
      off_cnt <= ONE_V;
    end else if (lo_q && want) begin
      lo_q    <= 1'b0;
      off_cnt <= ONE_V;
    end else if (!hi_q && !lo_q) begin
      if (off_cnt >= GAP_V) begin
        hi_q    <= want;
        lo_q    <= !want;
        off_cnt <= '0;
      end else begin
        off_cnt <= off_cnt + ONE_V;
      end
    end
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hi_q && lo_q));

  // R3
  dark_before_lit_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hi_q) || $rose(lo_q)) |-> $past(!hi_q && !lo_q));

  // R11
  disable_dark_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hi_q && !lo_q));

endmodule

// File: rtl/pwm_steer_core.sv
module pwm_steer_core
  import pwm_steer_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cyc_start,
  input  logic blank,
  input  logic trip,
  input  logic half_mode,
  input  logic soft_zero,
  output logic a_hi,
  output logic a_lo,
  output logic b_hi,
  output logic b_lo
);

  logic              latch_on;
  logic              mode_q;
  logic [NUM_CH-1:0] want;
  logic [NUM_CH-1:0] hi_v;
  logic [NUM_CH-1:0] lo_v;

  pwm_set_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .soft_zero (soft_zero),
    .blank     (blank),
    .cyc_start (cyc_start),
    .trip      (trip),
    .on_q      (latch_on)
  );

  pwm_phase_steer u_steer (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cyc_start (cyc_start),
    .half_mode (half_mode),
    .latch_on  (latch_on),
    .want      (want),
    .mode_q    (mode_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_stage
    pwm_bbm_stage #(
      .GAP_CYC (GAP_CYC)
    ) u_stage (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .want (want[c]),
      .hi_q (hi_v[c]),
      .lo_q (lo_v[c])
    );
  end

  assign a_hi = hi_v[0];
  assign a_lo = lo_v[0];
  assign b_hi = hi_v[1];
  assign b_lo = lo_v[1];

  // R5
  half_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && $past(mode_q)) |-> !(a_hi && b_hi));

  // R9
  dead_time_chk: assert property (@(posedge clk) disable iff (rst)
    blank |=> !latch_on);

endmodule

// File: tb/test_pwm_steer_core.sv
module test_pwm_steer_core;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 2;
  localparam int P          = 12;

  logic clk = 1'b0;
  logic rst, en, cyc_start, blank, trip, half_mode, soft_zero;
  logic a_hi, a_lo, b_hi, b_lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_steer_core #(.GAP_CYC(GAP)) i_pwm_steer_core (
    .clk(clk), .rst(rst), .en(en), .cyc_start(cyc_start), .blank(blank),
    .trip(trip), .half_mode(half_mode), .soft_zero(soft_zero),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
  );

  wire [3:0] obs = {a_hi, a_lo, b_hi, b_lo};

  typedef struct {
    int       at;
    logic [3:0] val;
    string    tag;
  } exp_t;

  exp_t sb[$];
  int   cyc    = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cycle %0d got %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // sorted insert into the scoreboard
  task automatic expect_at(input int at, input logic [3:0] val, input string tag);
    exp_t e;
    int   i;
    e.at = at; e.val = val; e.tag = tag;
    i = 0;
    while (i < sb.size() && sb[i].at <= at) i++;
    sb.insert(i, e);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.at < cyc) begin
        checks++; errors++;
        $display("FAIL %s: check for cycle %0d missed, got %b expected %b", e.tag, e.at, obs, e.val);
      end else begin
        chk(e.tag, obs, e.val);
      end
    end
  end

  task automatic drive(input bit st, input bit bl, input bit tr);
    @(negedge clk);
    cyc_start = st; blank = bl; trip = tr;
  endtask

  // one oscillator period; optional trips and a mid-cycle mode flip
  task automatic osc_cycle(input int t1, input int t2, input int flip_at);
    for (int k = 0; k < P; k++) begin
      drive(k == 0, k == P-1, (k == t1) || (k == t2));
      if (k == flip_at) half_mode = !half_mode;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    int s;
    rst = 1'b1; en = 1'b0; cyc_start = 1'b0; blank = 1'b0;
    trip = 1'b0; half_mode = 1'b0; soft_zero = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset state", obs, 4'b0000);
    rst = 1'b0; en = 1'b1;
    idle(4);
    chk("R11 low sides after enable", obs, 4'b0101);

    // full mode, trip at offset 6
    s = cyc + 2;
    expect_at(s + 1, 4'b0000, "R3 gap before high side");
    expect_at(s + 3, 4'b1010, "R1 R4 both high in phase");
    expect_at(s + 6, 4'b1010, "R4 still on before trip");
    expect_at(s + 7, 4'b0000, "R2 high off after trip");
    expect_at(s + 9, 4'b0101, "R2 low back after gap");
    osc_cycle(6, -1, -1);

    // overload: earlier trip, then a second trip while clear
    s = cyc + 2;
    expect_at(s + 4, 4'b1010, "R1 pulse on");
    expect_at(s + 5, 4'b0000, "R2 earlier trip shortens pulse");
    expect_at(s + 7, 4'b0101, "R2 low side after trip");
    expect_at(s + 10, 4'b0101, "R7 second trip ignored");
    osc_cycle(4, 8, -1);

    // no trip: dead time ends the pulse, next start with coincident trip
    s = cyc + 2;
    expect_at(s + 3, 4'b1010, "R1 pulse on");
    expect_at(s + 11, 4'b1010, "R9 on through dead-time edge");
    expect_at(s + 12, 4'b0000, "R9 off after dead time");
    expect_at(s + 13, 4'b0000, "R3 gap held");
    expect_at(s + 14, 4'b1010, "R9 next pulse after gap");
    expect_at(s + 18, 4'b1010, "R8 start wins over coincident trip");
    expect_at(s + 23, 4'b1010, "R8 pulse runs to dead time");
    osc_cycle(-1, -1, -1);
    osc_cycle(0, -1, -1);
    s = cyc + 2;
    expect_at(s, 4'b0000, "R9 off after dead time");
    expect_at(s + 2, 4'b0101, "R3 low after gap");
    idle(4);

    // soft zero
    soft_zero = 1'b1;
    s = cyc + 2;
    expect_at(s + 3, 4'b0101, "R10 no pulse under soft zero");
    expect_at(s + 8, 4'b0101, "R10 still no pulse");
    osc_cycle(-1, -1, -1);
    soft_zero = 1'b0;
    idle(2);

    // disable, then alternating mode
    @(negedge clk);
    en = 1'b0; cyc_start = 1'b0; blank = 1'b0; trip = 1'b0;
    expect_at(cyc + 1, 4'b0000, "R11 disable forces all off");
    idle(2);
    en = 1'b1; half_mode = 1'b1;
    idle(4);
    chk("R11 low sides after re-enable", obs, 4'b0101);

    s = cyc + 2;
    expect_at(s + 3, 4'b1001, "R5 first cycle to A");
    expect_at(s + 7, 4'b0001, "R2 A off after trip");
    expect_at(s + 9, 4'b0101, "R5 A low again");
    osc_cycle(6, -1, -1);
    s = cyc + 2;
    expect_at(s + 3, 4'b0110, "R5 second cycle to B");
    expect_at(s + 9, 4'b0101, "R5 B low again");
    osc_cycle(6, -1, -1);
    s = cyc + 2;
    expect_at(s + 3, 4'b1001, "R5 third cycle back to A");
    osc_cycle(6, -1, -1);

    // B cycle with mode flip mid-cycle
    s = cyc + 2;
    expect_at(s + 3, 4'b0110, "R6 flip waits for next start");
    expect_at(s + 5, 4'b0110, "R6 A stays off");
    osc_cycle(6, -1, 2);
    s = cyc + 2;
    expect_at(s + 3, 4'b1010, "R6 full mode after next start");
    osc_cycle(6, -1, -1);
    idle(6);

    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1: %0d expectations never compared, got %0d expected 0", sb.size(), 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule